// File: doc/BRIEF.md
# Pulse Period Sweep Unit

This block bends the pitch of a pulse tone by rewriting its 11-bit timer period at a fixed pace. A slow tick strobe arrives as a one-cycle enable, nominally 120 times a second. A small divider counts those ticks. Each time the divider completes an interval, the block shifts the current period right, then adds that shifted value to the period or subtracts it. Adding lowers the pitch and subtracting raises it.

While the sweep is switched off, the base period passes straight to the output and the internal period tracks it. A load strobe copies the base period into the working period and restarts the divider. The block raises a mute flag in two cases: when the period is too short to make an audible tone, and when the next upward step would overflow 11 bits. A step that would overflow is never applied.

Top module: `sweep_unit`

## Requirements
- R1: While `enable` is low, `period_out` equals `base_period` in the same cycle. Ticks have no effect, and the working period follows `base_period`.
- R2: With `negate` = 0, an update replaces the working period P with P + (P >> `shift_amt`).
- R3: With `negate` = 1, an update replaces P with P - (P >> `shift_amt`).
- R4: While enabled, the divider counts ticks. An update happens on every (`sweep_period` + 1)-th tick, so `sweep_period` = 0 updates on every tick and 7 updates on every eighth tick. A cycle with no tick leaves the period unchanged.
- R5: With `negate` = 0 and a nonzero shift, if P + (P >> `shift_amt`) exceeds 0x7FF, the period is held and `mute` is 1 while enabled.
- R6: `mute` is 1 whenever `period_out` is below 8.
- R7: A `shift_amt` of 0 never changes the period, even when an interval completes.
- R8: A `load` pulse sets the working period to `base_period` and clears the divider, so the next update needs a full (`sweep_period` + 1) ticks.
- R9: After reset the working period and the divider are 0, so with `enable` high and no load, `period_out` = 0 and `mute` = 1.
- R10: A tick that completes an interval changes `period_out` at the clock edge on which the tick is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle sweep tick enable |
| sweep_period | input | 3 | Divider interval minus one, in ticks |
| shift_amt | input | 3 | Right-shift amount applied to the period |
| negate | input | 1 | 1 = subtract the shifted period, 0 = add it |
| enable | input | 1 | Sweep on |
| load | input | 1 | Reload the working period from the base period and clear the divider |
| base_period | input | 11 | Programmed timer period |
| period_out | output | 11 | Current timer period |
| mute | output | 1 | Silence request: period below 8 or upward overflow |

## Verification
The bench targets the divider boundary by stopping one tick short of an interval and then completing it. A design off by one in the divider would update early or late. An upward step from 0x600 by half must be refused. A design that wrapped the sum would jump to 0x100 instead of holding with `mute` high. A zero shift with the interval complete must leave the period alone, whereas a design that doubled the period there would show it moving. A load part-way through an interval must restart the count. Subtraction steps are walked down past 8, where `mute` must rise at exactly the crossing.

// File: rtl/sweep_unit.sv
module sweep_unit #(
  parameter int PW = 11,
  parameter int SW = 3,
  parameter int DW = 3,
  parameter int MIN_PERIOD = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] sweep_period,
  input  logic [SW-1:0] shift_amt,
  input  logic          negate,
  input  logic          enable,
  input  logic          load,
  input  logic [PW-1:0] base_period,
  output logic [PW-1:0] period_out,
  output logic          mute
);

  logic [PW-1:0] cur_q;
  logic [DW-1:0] div_q;
  logic [PW-1:0] shifted;
  logic [PW:0]   target;
  logic          overflow;
  logic          step;

  assign shifted  = cur_q >> shift_amt;
  assign target   = negate ? ({1'b0, cur_q} - {1'b0, shifted})
                           : ({1'b0, cur_q} + {1'b0, shifted});
  assign overflow = !negate && target[PW] && (shift_amt != '0);
  assign step     = tick && (div_q == sweep_period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      div_q <= '0;
    end else if (load || !enable) begin
      cur_q <= base_period;
      div_q <= '0;
    end else if (tick) begin
      if (step) begin
        div_q <= '0;
        if (shift_amt != '0 && !overflow) cur_q <= target[PW-1:0];
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  assign period_out = enable ? cur_q : base_period;
  assign mute       = (period_out < PW'(MIN_PERIOD)) || (enable && overflow);

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick && !load) |=> $stable(cur_q));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && !load && !negate) |=> (cur_q >= $past(cur_q)));

  p_sub_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && !load && negate) |=> (cur_q <= $past(cur_q)));

  p_zero_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !load && shift_amt == '0) |=> $stable(cur_q));

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (div_q == '0 && cur_q == $past(base_period)));

  p_mute_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (period_out < PW'(MIN_PERIOD)) |-> mute);

endmodule

// File: tb/tb_sweep_unit.sv
module tb_sweep_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick = 0;
  logic [2:0]  sweep_period = 0;
  logic [2:0]  shift_amt = 0;
  logic        negate = 0;
  logic        enable = 0;
  logic        load = 0;
  logic [10:0] base_period = 0;
  logic [10:0] period_out;
  logic        mute;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sweep_unit dut (.clk(clk), .rst_n(rst_n), .tick(tick), .sweep_period(sweep_period),
    .shift_amt(shift_amt), .negate(negate), .enable(enable), .load(load),
    .base_period(base_period), .period_out(period_out), .mute(mute));

  // {base, shift, negate, sweep_period, ticks, expected period, expected mute}
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {11'h100, 3'd1, 1'b0, 3'd0, 4'd1, 11'h180, 1'b0},  // R2
    {11'h100, 3'd1, 1'b1, 3'd0, 4'd1, 11'h080, 1'b0},  // R3
    {11'h100, 3'd2, 1'b0, 3'd1, 4'd1, 11'h100, 1'b0},  // R4 one short
    {11'h100, 3'd2, 1'b0, 3'd1, 4'd2, 11'h140, 1'b0},  // R4
    {11'h200, 3'd3, 1'b0, 3'd0, 4'd2, 11'h288, 1'b0},  // R2 twice
    {11'h600, 3'd1, 1'b0, 3'd0, 4'd1, 11'h600, 1'b1},  // R5
    {11'h300, 3'd0, 1'b0, 3'd0, 4'd3, 11'h300, 1'b0},  // R7
    {11'h005, 3'd1, 1'b0, 3'd0, 4'd0, 11'h005, 1'b1},  // R6
    {11'h010, 3'd1, 1'b1, 3'd0, 4'd1, 11'h008, 1'b0},  // R6 edge
    {11'h010, 3'd1, 1'b1, 3'd0, 4'd2, 11'h004, 1'b1},  // R6 R3
    {11'h3FF, 3'd7, 1'b0, 3'd7, 4'd7, 11'h3FF, 1'b0},  // R4 one short
    {11'h3FF, 3'd7, 1'b0, 3'd7, 4'd8, 11'h406, 1'b0}   // R4 R10
  };

  task automatic check(string req, logic [10:0] ep, logic em);
    tests++;
    if (period_out !== ep || mute !== em) begin
      fails++;
      $display("FAIL %s: period=%h mute=%b expected period=%h mute=%b", req, period_out, mute, ep, em);
    end
  endtask

  task automatic pulse_ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk);
      tick = 0; @(negedge clk);
    end
  endtask

  task automatic do_load();
    load = 1; @(negedge clk);
    load = 0;
  endtask

  initial begin
    #2000000;
    fails++; tests++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    enable = 1; base_period = 11'h123;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset", 11'h000, 1'b1);

    for (int v = 0; v < NV; v++) begin
      enable = 0;
      base_period = VEC[v][33:23]; shift_amt = VEC[v][22:20]; negate = VEC[v][19];
      sweep_period = VEC[v][18:16];
      @(negedge clk);
      do_load();
      enable = 1;
      @(negedge clk);
      pulse_ticks(int'(VEC[v][15:12]));
      check($sformatf("R2-table vector %0d", v), VEC[v][11:1], VEC[v][0]);
    end

    // R1: passthrough, ticks ignored
    enable = 0; base_period = 11'h222; shift_amt = 1; negate = 0; sweep_period = 0;
    #1; check("R1 passthrough", 11'h222, 1'b0);
    pulse_ticks(3);
    check("R1 ticks ignored", 11'h222, 1'b0);
    base_period = 11'h004;
    #1; check("R1 R6 follow", 11'h004, 1'b1);

    // R1: enabling after disabled starts from base
    base_period = 11'h100; @(negedge clk);
    enable = 1; @(negedge clk);
    check("R1 enable start", 11'h100, 1'b0);

    // R10: update lands on the sampled edge
    tick = 1; @(posedge clk); #1;
    tick = 0;
    check("R10 edge", 11'h180, 1'b0);
    @(negedge clk);

    // R8: load mid interval clears divider
    sweep_period = 1; base_period = 11'h100;
    do_load(); @(negedge clk);
    pulse_ticks(1);
    check("R8 one tick in", 11'h100, 1'b0);
    base_period = 11'h200;
    do_load(); @(negedge clk);
    pulse_ticks(1);
    check("R8 after reload no step", 11'h200, 1'b0);
    pulse_ticks(1);
    check("R8 full interval", 11'h300, 1'b0);

    // R4: idle cycles leave period alone
    repeat (5) @(negedge clk);
    check("R4 no tick", 11'h300, 1'b0);

    // R5: overflow holds across repeated ticks
    base_period = 11'h7F0; sweep_period = 0; shift_amt = 3;
    do_load(); @(negedge clk);
    pulse_ticks(2);
    check("R5 hold", 11'h7F0, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule